// File: doc/BRIEF.md
# Receive Byte Queue with Latched Event Interrupts

This block buffers bytes arriving from a serial slave shifter and hands them to a CPU one at a time. The shifter offers a byte with a one-cycle valid strobe; the CPU reads the oldest byte from `pop_data` and takes it with a one-cycle `pop` strobe. The queue holds eight bytes by default.

Three events are latched into a status register: the queue reaching its half-depth threshold, the queue becoming full, and the queue being drained to empty by a pop. Each latch stays set until software writes 0 to it. Software may also write 1 to force a latch on. A control register holds the queue enable and one interrupt enable per event. A single registered interrupt line is the OR of every latched event whose enable is set.

Software reaches both registers through a small write/select port. `reg_sel` = 0 selects control and `reg_sel` = 1 selects status. Read data is combinational from the selected register.

Top module: `rxbuf_evt_top`

## Requirements
- R1: After reset the control register, the status register, `irq`, the stored count and `pop_data` are all 0.
- R2: Bytes leave in arrival order. `pop_data` shows the oldest stored byte, and up to DEPTH (8) bytes are held.
- R3: A byte offered while DEPTH bytes are stored and no pop is taken is dropped. The stored bytes and the latches are left unchanged.
- R4: A pop while the queue is empty reads 0 and leaves the count unchanged. It does not set the empty latch.
- R5: Status bit 1 (threshold) is set at the clock edge where a push without a pop takes the count from THRESH-1 to THRESH (THRESH = 4).
- R6: Status bit 3 (full) is set at the clock edge where a push without a pop takes the count from DEPTH-1 to DEPTH.
- R7: Status bit 0 (empty) is set at the clock edge where a pop without a push takes the count from 1 to 0.
- R8: A set status bit stays set until software writes 0 to that bit position of the status register.
- R9: A software write of 1 to status bit 3, 1 or 0 sets that bit.
- R10: `irq` is 1 exactly one cycle after some status bit and its enable are both 1. The enables are control bit 3 (full), bit 1 (threshold) and bit 0 (empty).
- R11: Control bit 7 enables the queue. While it reads 0 the queue is flushed to empty, offered bytes are ignored, and `pop_data` is 0.
- R12: Reserved bits read 0 and ignore writes. These are bits 6:4 and 2 of control, and bits 7:4 and 2 of status.
- R13: A latch is set only on the count transition. Holding the count at THRESH after software has cleared the threshold bit leaves it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | Incoming byte strobe from the shifter |
| byte_data | input | WIDTH | Incoming byte |
| pop | input | 1 | CPU takes the oldest byte |
| pop_data | output | WIDTH | Oldest stored byte, 0 when empty |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = status register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register contents |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its defaults: an eight-byte queue and a threshold of four. With these values every latch can be set with a handful of pushes, and the full and overflow corners are reached in under ten bytes. Each transition can be reached in isolation: the threshold crossing without a full event, a full event after the threshold bit was cleared, and the drain to empty. A scoreboard queue predicts every popped byte, including the byte dropped at full, and the flush when the enable bit drops.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

  localparam int unsigned CTL_EN_BIT = 7;
  localparam int unsigned EV_FULL_BIT = 3;
  localparam int unsigned EV_THR_BIT = 1;
  localparam int unsigned EV_EMPTY_BIT = 0;

  typedef struct packed {
    logic full;
    logic thr;
    logic empty;
  } evt_t;

  // Next pointer position with wrap at the queue depth.
  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // A push alone lands the count on 'lvl'.
  function automatic logic step_into(int unsigned cnt, int unsigned lvl,
                                     logic up, logic down);
    return up && !down && (cnt + 1 == lvl);
  endfunction

  // A pop alone takes the last byte.
  function automatic logic step_out(int unsigned cnt, logic up, logic down);
    return down && !up && (cnt == 1);
  endfunction

  function automatic evt_t bits_to_evt(logic [7:0] v);
    return '{full: v[EV_FULL_BIT], thr: v[EV_THR_BIT], empty: v[EV_EMPTY_BIT]};
  endfunction

  function automatic logic [7:0] evt_to_bits(evt_t e);
    logic [7:0] v;
    v = '0;
    v[EV_FULL_BIT] = e.full;
    v[EV_THR_BIT] = e.thr;
    v[EV_EMPTY_BIT] = e.empty;
    return v;
  endfunction

endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             push_req,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_req,
  output logic [WIDTH-1:0] head_data,
  output logic [CNT_W-1:0] count,
  output logic             push_ok,
  output logic             pop_ok
);
  import rxbuf_pkg::*;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             is_full, is_empty;
  logic             drop_evt;

  assign is_full  = (count == CNT_W'(DEPTH));
  assign is_empty = (count == '0);
  assign pop_ok   = en && pop_req && !is_empty;
  assign push_ok  = en && push_req && (!is_full || pop_ok);
  assign drop_evt = en && push_req && is_full && !pop_ok;
  assign head_data = is_empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (!en) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= PTR_W'(wrap_inc(32'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= PTR_W'(wrap_inc(32'(rd_ptr), DEPTH));
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (count == CNT_W'(DEPTH)) && $stable(wr_ptr));

  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && is_empty && !push_req) |=> (count == '0) && $stable(rd_ptr));

  p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (count == '0));

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

endmodule

// File: rtl/rxbuf_flags.sv
module rxbuf_flags #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned THRESH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             push_ok,
  input  logic             pop_ok,
  input  logic             sw_wr,
  input  rxbuf_pkg::evt_t  sw_val,
  input  rxbuf_pkg::evt_t  ie,
  output rxbuf_pkg::evt_t  stat,
  output logic             irq
);
  import rxbuf_pkg::*;

  evt_t hit;
  evt_t stat_n;

  always_comb begin
    hit.thr   = step_into(32'(count), THRESH, push_ok, pop_ok);
    hit.full  = step_into(32'(count), DEPTH, push_ok, pop_ok);
    hit.empty = step_out(32'(count), push_ok, pop_ok);
    stat_n    = evt_t'((sw_wr ? sw_val : stat) | hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      irq  <= 1'b0;
    end else begin
      stat <= stat_n;
      irq  <= |(stat & ie);
    end
  end

  p_thr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit.thr |=> stat.thr);

  p_full_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit.full |=> stat.full);

  p_empty_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit.empty |=> stat.empty);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat.full && !sw_wr) |=> stat.full);

  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(stat & ie) != '0));

endmodule

// File: rtl/rxbuf_evt_top.sv
module rxbuf_evt_top #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned THRESH = DEPTH / 2,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic [WIDTH-1:0] byte_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq
);
  import rxbuf_pkg::*;

  logic             en_q;
  evt_t             ie_q;
  evt_t             stat;
  logic [CNT_W-1:0] count;
  logic             push_ok, pop_ok;
  logic             ctl_wr, st_wr;

  assign ctl_wr = reg_wr && !reg_sel;
  assign st_wr  = reg_wr && reg_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      ie_q <= '0;
    end else if (ctl_wr) begin
      en_q <= reg_wdata[CTL_EN_BIT];
      ie_q <= bits_to_evt(reg_wdata);
    end
  end

  always_comb begin
    if (reg_sel) begin
      reg_rdata = evt_to_bits(stat);
    end else begin
      reg_rdata = evt_to_bits(ie_q);
      reg_rdata[CTL_EN_BIT] = en_q;
    end
  end

  rxbuf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_q),
    .push_req  (byte_vld),
    .push_data (byte_data),
    .pop_req   (pop),
    .head_data (pop_data),
    .count     (count),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok)
  );

  rxbuf_flags #(.DEPTH(DEPTH), .THRESH(THRESH)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .count   (count),
    .push_ok (push_ok),
    .pop_ok  (pop_ok),
    .sw_wr   (st_wr),
    .sw_val  (bits_to_evt(reg_wdata)),
    .ie      (ie_q),
    .stat    (stat),
    .irq     (irq)
  );

  p_reserved_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & (reg_sel ? 8'hF4 : 8'h74)) == 8'h00);

endmodule

// File: tb/rxbuf_evt_top_test.sv
module rxbuf_evt_top_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_data = '0;
  logic       pop = 1'b0;
  logic [7:0] pop_data;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] sb[$];
  logic model_en = 1'b0;

  always #10ns clk = ~clk;

  rxbuf_evt_top uut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .pop(pop), .pop_data(pop_data), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic rd_check(string req, logic sel, logic [7:0] exp);
    reg_sel = sel;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic wr_reg(logic sel, logic [7:0] val);
    reg_sel = sel; reg_wdata = val; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
    if (!sel) begin
      model_en = val[7];
      if (!val[7]) sb.delete();
    end
  endtask

  // Driver: offers a byte and predicts whether it is stored.
  task automatic push_byte(logic [7:0] d);
    byte_vld = 1'b1; byte_data = d;
    tick();
    byte_vld = 1'b0;
    if (model_en && sb.size() < 8) sb.push_back(d);
  endtask

  // Monitor: compares the head against the scoreboard, then takes it.
  task automatic pop_byte(string req);
    logic [7:0] exp;
    exp = (sb.size() > 0) ? sb[0] : 8'h00;
    #1;
    check(req, pop_data, exp);
    pop = 1'b1;
    tick();
    pop = 1'b0;
    if (sb.size() > 0) void'(sb.pop_front());
  endtask

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    rd_check("R1 control", 1'b0, 8'h00);
    rd_check("R1 status", 1'b1, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 pop_data", pop_data, 8'h00);

    // R12 reserved bits
    wr_reg(1'b0, 8'hFF);
    rd_check("R12 control", 1'b0, 8'h8B);
    wr_reg(1'b0, 8'h8B);
    tick();
    wr_reg(1'b1, 8'h00);

    // R4 pop while empty
    pop_byte("R4 empty pop");
    rd_check("R4 no empty flag", 1'b1, 8'h00);

    // R5 threshold
    push_byte(8'h11); push_byte(8'h22); push_byte(8'h33);
    rd_check("R5 below threshold", 1'b1, 8'h00);
    push_byte(8'h44);
    rd_check("R5 threshold set", 1'b1, 8'h02);
    tick();
    check("R10 irq raised", {7'd0, irq}, 8'h01);

    // R8 clear by writing 0, R10 irq falls
    wr_reg(1'b1, 8'h00);
    rd_check("R8 cleared", 1'b1, 8'h00);
    tick();
    check("R10 irq dropped", {7'd0, irq}, 8'h00);

    // R13 level held does not re-set
    repeat (3) tick();
    rd_check("R13 no re-set", 1'b1, 8'h00);

    // R6 full
    push_byte(8'h55); push_byte(8'h66); push_byte(8'h77);
    rd_check("R6 not yet full", 1'b1, 8'h00);
    push_byte(8'h88);
    rd_check("R6 full set", 1'b1, 8'h08);

    // R3 drop at full
    push_byte(8'hEE);
    rd_check("R3 flags unchanged", 1'b1, 8'h08);

    // R2 order, R7 empty on drain
    for (int i = 0; i < 8; i++) pop_byte("R2 order");
    rd_check("R7 empty set", 1'b1, 8'h09);
    pop_byte("R4 pop after drain");

    // R8 sticky, selective clear
    repeat (3) tick();
    rd_check("R8 sticky", 1'b1, 8'h09);
    wr_reg(1'b1, 8'h01);
    rd_check("R8 clear full only", 1'b1, 8'h01);

    // R9 software set, R12 status reserved
    wr_reg(1'b1, 8'hFF);
    rd_check("R9 set all", 1'b1, 8'h0B);
    wr_reg(1'b0, 8'h80);
    repeat (2) tick();
    check("R10 gated off", {7'd0, irq}, 8'h00);
    wr_reg(1'b0, 8'h81);
    tick();
    check("R10 empty enable", {7'd0, irq}, 8'h01);

    // R11 disable flushes and ignores bytes
    wr_reg(1'b1, 8'h00);
    push_byte(8'hA1); push_byte(8'hA2);
    wr_reg(1'b0, 8'h00);
    push_byte(8'hB1);
    tick();
    #1;
    check("R11 disabled pop_data", pop_data, 8'h00);
    rd_check("R11 no flag on flush", 1'b1, 8'h00);
    wr_reg(1'b0, 8'h80);
    pop_byte("R11 empty after flush");
    push_byte(8'hC3);
    pop_byte("R11 works again");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule